// File: doc/BRIEF.md
# Hybrid coarse/fine digital PWM

This block produces a fixed-frequency pulse-width-modulated output from an N-bit duty command. It splits the command into two parts. The upper bits pick one coarse cycle out of the switching period, using a synchronous counter. The lower bits place the falling edge inside that coarse cycle, using a chain of 2^M delay cells. An edge is injected into the chain at a position chosen by a one-hot control word, and it then travels to the shared chain output. The taps are never multiplexed.

The output is an SR flop. The period counter sets it when a period begins, and the chain output clears it. For synthesis and self-checking simulation, each delay cell is one tick of the fast clock `clk`, so a switching period lasts 2^N ticks. A coarse cycle is 2^M ticks long. The coarse counter therefore advances only 2^(N-M) times per period, where a plain counter-and-comparator design would need 2^N steps.

The duty command may change at any time. It is copied into a shadow register on the last tick of each period, so every period uses exactly one duty value.

Top module: `hybrid_pwm`

## Requirements
- R1: The duty command is split into a coarse field, bits DUTY_W-1..FINE_W, and a fine field, bits FINE_W-1..0. The defaults are DUTY_W=8 and FINE_W=4. The coarse field is weighted by 2^FINE_W fast ticks and the fine field by one tick.
- R2: A switching period lasts 2^DUTY_W fast ticks, made of 2^(DUTY_W-FINE_W) coarse cycles of 2^FINE_W ticks each. `pwm_o` is high on the first tick of every period.
- R3: In each period, `pwm_o` is high for exactly coarse×2^FINE_W + fine + 1 consecutive ticks, starting at the first tick of the period, and then stays low until the period ends.
- R4: The chain is released exactly once per period, on the first tick of the coarse cycle whose counter value equals the coarse field.
- R5: The fine field is decoded into a one-hot entry word with one bit per cell. Each bit is combined with the shared release trigger through a NAND, so at most one entry point fires on any tick.
- R6: A change on `duty_i` takes effect only from the next period boundary. The value present on the last tick of a period governs the whole of the next period, and changes made in the middle of a period do not alter the current pulse.
- R7: A duty of 0 gives a one-tick pulse. The all-ones duty keeps `pwm_o` high for the whole period, because a set at the period boundary wins over a clear on the same tick.
- R8: While `rst_n` is low, `pwm_o` is 0. The first period after reset uses a duty of 0, whatever value is on `duty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one tick equals one delay cell |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_i | input | DUTY_W | Duty command, applied from the next period |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with the default DUTY_W=8 and FINE_W=4. With these values a period is only 256 ticks, so every one of the 256 duty codes can be swept, one code per period, and both ends of the range are reached. Each period also receives a different, random duty value in the middle of the period before its final value is set. This shows that mid-period updates never leak into the current pulse. It also checks that the fine-field wrap into the next coarse cycle adds exactly one tick per code.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;

  // Command applied to the output SR flop on one tick
  typedef enum logic [1:0] {
    SR_HOLD = 2'd0,
    SR_SET  = 2'd1,
    SR_CLR  = 2'd2
  } sr_cmd_e;

  // Set has priority over clear on the same tick
  function automatic sr_cmd_e sr_resolve(input logic set_req, input logic clr_req);
    if (set_req) return SR_SET;
    if (clr_req) return SR_CLR;
    return SR_HOLD;
  endfunction

endpackage

// File: rtl/hpwm_timebase.sv
module hpwm_timebase #(
  parameter int FINE_W = 4,
  parameter int CRS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [FINE_W-1:0] phase_o,
  output logic [CRS_W-1:0]  crs_o,
  output logic              coarse_en_o,
  output logic              period_start_o,
  output logic              last_tick_o
);
  localparam logic [FINE_W-1:0] PH_MAX  = '1;
  localparam logic [CRS_W-1:0]  CRS_MAX = '1;

  logic [FINE_W-1:0] phase_q;
  logic [CRS_W-1:0]  crs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      crs_q   <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (phase_q == PH_MAX) crs_q <= crs_q + 1'b1;
    end
  end

  assign phase_o        = phase_q;
  assign crs_o          = crs_q;
  assign coarse_en_o    = (phase_q == '0);
  assign period_start_o = (phase_q == '0) && (crs_q == '0);
  assign last_tick_o    = (phase_q == PH_MAX) && (crs_q == CRS_MAX);
endmodule

// File: rtl/hpwm_fine_line.sv
module hpwm_fine_line #(
  parameter int FINE_W = 4,
  localparam int CELLS = 1 << FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FINE_W-1:0] fine_i,
  input  logic              trig_i,
  output logic [CELLS-1:0]  entry_o,
  output logic              edge_o
);
  // One-hot control word: bit k marks entry at cell k (k cells from the output)
  function automatic logic [CELLS-1:0] decode_entry(input logic [FINE_W-1:0] f);
    logic [CELLS-1:0] w;
    w    = '0;
    w[f] = 1'b1;
    return w;
  endfunction

  logic [CELLS-1:0] ctrl_word;
  logic [CELLS-1:0] gate_n;
  logic [CELLS-1:0] cell_d;
  logic [CELLS-1:0] cell_q;

  assign ctrl_word = decode_entry(fine_i);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    // Shared trigger gates every decoder output
    assign gate_n[i]  = ~(ctrl_word[i] & trig_i);
    assign entry_o[i] = ~gate_n[i];
    if (i == CELLS - 1) begin : g_head
      assign cell_d[i] = entry_o[i];
    end else begin : g_body
      assign cell_d[i] = cell_q[i+1] | entry_o[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assign edge_o = cell_q[0];
endmodule

// File: rtl/hpwm_sr_out.sv
module hpwm_sr_out (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import hpwm_pkg::*;

  sr_cmd_e cmd;
  assign cmd = sr_resolve(set_i, clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else begin
      case (cmd)
        SR_SET:  q_o <= 1'b1;
        SR_CLR:  q_o <= 1'b0;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/hybrid_pwm.sv
module hybrid_pwm #(
  parameter int DUTY_W = 8,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int CRS_W = DUTY_W - FINE_W;
  localparam int CELLS = 1 << FINE_W;

  logic [DUTY_W-1:0] shadow_q;
  logic [FINE_W-1:0] phase;
  logic [CRS_W-1:0]  crs;
  logic              coarse_en;
  logic              period_start;
  logic              last_tick;
  logic [CRS_W-1:0]  crs_field;
  logic [FINE_W-1:0] fine_field;
  logic              trig;
  logic [CELLS-1:0]  entry;
  logic              chain_out;

  // R6: the command is captured only on the last tick of a period
  always_ff @(posedge clk) begin
    if (!rst_n)         shadow_q <= '0;
    else if (last_tick) shadow_q <= duty_i;
  end

  // R1: field split
  assign crs_field  = shadow_q[DUTY_W-1:FINE_W];
  assign fine_field = shadow_q[FINE_W-1:0];

  hpwm_timebase #(.FINE_W(FINE_W), .CRS_W(CRS_W)) u_tb (
    .clk            (clk),
    .rst_n          (rst_n),
    .phase_o        (phase),
    .crs_o          (crs),
    .coarse_en_o    (coarse_en),
    .period_start_o (period_start),
    .last_tick_o    (last_tick)
  );

  // R4: release only at the start of the matching coarse cycle
  assign trig = coarse_en && (crs == crs_field);

  hpwm_fine_line #(.FINE_W(FINE_W)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .fine_i  (fine_field),
    .trig_i  (trig),
    .entry_o (entry),
    .edge_o  (chain_out)
  );

  hpwm_sr_out u_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (period_start),
    .clr_i (chain_out),
    .q_o   (pwm_o)
  );
endmodule

// File: rtl/hybrid_pwm_chk.sv
module hybrid_pwm_chk #(
  parameter int DUTY_W = 8,
  parameter int FINE_W = 4,
  localparam int CELLS = 1 << FINE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_o,
  input logic              period_start,
  input logic              last_tick,
  input logic              trig,
  input logic [CELLS-1:0]  entry,
  input logic              chain_out,
  input logic [DUTY_W-1:0] shadow_q
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            seen_q <= 1'b0;
    else if (period_start) seen_q <= trig;
    else                   seen_q <= seen_q | trig;
  end

  // R2
  set_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> pwm_o);

  // R3
  clear_by_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_out && !period_start) |=> !pwm_o);

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && !chain_out) |=> $stable(pwm_o));

  // R5
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry));

  // R4
  one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !period_start) |-> !seen_q);

  // R4
  release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |-> (seen_q || trig));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_tick |=> $stable(shadow_q));
endmodule

bind hybrid_pwm hybrid_pwm_chk #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_o        (pwm_o),
  .period_start (period_start),
  .last_tick    (last_tick),
  .trig         (trig),
  .entry        (entry),
  .chain_out    (chain_out),
  .shadow_q     (shadow_q)
);

// File: tb/hybrid_pwm_test.sv
`timescale 1ns/1ps
module hybrid_pwm_test;
  localparam int DUTY_W = 8;
  localparam int FINE_W = 4;
  localparam int PER    = 1 << DUTY_W;
  localparam int NRAND  = 24;

  typedef struct {
    int    exp_hi;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DUTY_W-1:0] duty_i = '0;
  logic              pwm_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned tick = 0;
  bit          run = 1'b0;
  exp_t        sb_q[$];

  always #2.5 clk = ~clk;

  hybrid_pwm #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) uut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .pwm_o(pwm_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R1/R3: expected high ticks = coarse*2^FINE_W + fine + 1
  function automatic int model_high(input int d);
    int c, f;
    c = d / (1 << FINE_W);
    f = d % (1 << FINE_W);
    return c * (1 << FINE_W) + f + 1;
  endfunction

  task automatic goto_tick(input int unsigned t);
    do begin
      @(negedge clk);
      #1;
    end while (tick < t);
  endtask

  // Driver: mid-period glitch value, then the final value for the next period
  task automatic drive_period(input int unsigned p, input int d, input string tag);
    exp_t e;
    goto_tick(p * PER + 100);
    duty_i = DUTY_W'($urandom);
    goto_tick(p * PER + 200);
    duty_i = DUTY_W'(d);
    e.exp_hi = model_high(d);
    e.tag    = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: counts high ticks of every period and compares with the scoreboard
  int  hi_cnt = 0;
  bit  fell = 1'b0;
  bit  broken = 1'b0;
  bit  prev = 1'b0;
  always @(negedge clk) begin
    if (run) begin
      int unsigned idx;
      idx = tick % PER;
      if (idx == 0) begin
        // R2: high on the first tick of each period
        check(pwm_o == 1'b1, "R2 period start", int'(pwm_o), 1);
        hi_cnt = 0; fell = 1'b0; broken = 1'b0;
      end else begin
        if (prev && !pwm_o) fell = 1'b1;
        if (fell && pwm_o) broken = 1'b1;
      end
      if (pwm_o) hi_cnt++;
      prev = pwm_o;
      if (idx == PER - 1) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R3 scoreboard empty", hi_cnt, -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(hi_cnt == e.exp_hi, e.tag, hi_cnt, e.exp_hi);
          // R3: one contiguous pulse
          check(!broken, "R3 contiguous pulse", int'(broken), 0);
        end
      end
      tick++;
    end
  end

  initial begin
    exp_t e0;
    int unsigned p;
    duty_i = 8'd200;
    rst_n  = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      // R8: output low during reset
      check(pwm_o == 1'b0, "R8 reset low", int'(pwm_o), 0);
    end
    // R8: first period after reset runs with duty 0
    e0.exp_hi = 1;
    e0.tag    = "R8 first period duty 0";
    sb_q.push_back(e0);
    #1;
    rst_n = 1'b1;
    run   = 1'b1;
    p = 0;
    // R3/R7 sweep of every code (R4, R5 exercised by each release)
    for (int d = 0; d < PER; d++) begin
      string tg;
      if (d == 0)            tg = "R7 duty zero";
      else if (d == PER - 1) tg = "R7 duty full";
      else                   tg = $sformatf("R3 duty %0d", d);
      drive_period(p, d, tg);
      p++;
    end
    // R6: random final values after mid-period disturbances
    for (int k = 0; k < NRAND; k++) begin
      drive_period(p, int'($urandom_range(PER - 1, 0)), "R6 random update");
      p++;
    end
    goto_tick((p + 1) * PER + 2);
    check(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule